// File: doc/BRIEF.md
# Timed Three-Lamp Signal Sequencer

This block sequences a single signal head through its three lamps: red, then green, then amber, then red again. It does not measure time itself. Each lamp has its own expiry input, driven by an external timer, and the sequencer advances out of the lit lamp only when that lamp's expiry input is high at a rising clock edge. Expiry inputs that belong to a lamp that is not lit have no effect.

The state register holds one bit per lamp, and the lamp outputs are those bits, with no gates between them and the pins. Red is bit 2, green is bit 1 and amber is bit 0 of the state, so the legal states are 3'b100, 3'b010 and 3'b001. An active-high asynchronous reset lights red at once. A corrupted state value, meaning anything other than the three legal codes, is replaced by red at the next rising edge.

The lamp outputs are plain level signals that hold between clock edges. There is no handshake: the timers sample the lamps, and the lamps sample the expiry inputs, once per clock.

Top module: `lamp_sequencer`

## Requirements
- R1: While `rst_i` is high, the outputs show red only (`lamp_red_o`=1, `lamp_green_o`=0, `lamp_amber_o`=0). This takes effect as soon as reset rises, without waiting for a clock edge.
- R2: With red lit, a rising edge where `red_done_i` is 1 lights green only. A rising edge where `red_done_i` is 0 keeps red.
- R3: With green lit, a rising edge where `green_done_i` is 1 lights amber only. A rising edge where `green_done_i` is 0 keeps green.
- R4: With amber lit, a rising edge where `amber_done_i` is 1 lights red only. A rising edge where `amber_done_i` is 0 keeps amber.
- R5: An expiry input whose lamp is not lit has no effect on the next state, whatever its level.
- R6: In every state reached from reset or from a legal state, exactly one lamp output is high. The state code, written as {red, green, amber}, is 100, 010 or 001.
- R7: If the state holds any other 3-bit value, the next rising edge restores red only (code 100).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; all state changes happen on its rising edge |
| rst_i | input | 1 | Asynchronous active-high reset to red |
| red_done_i | input | 1 | Red interval has expired; advance to green |
| green_done_i | input | 1 | Green interval has expired; advance to amber |
| amber_done_i | input | 1 | Amber interval has expired; advance to red |
| lamp_red_o | output | 1 | Red lamp drive; state bit 2 |
| lamp_amber_o | output | 1 | Amber lamp drive; state bit 0 |
| lamp_green_o | output | 1 | Green lamp drive; state bit 1 |

## Verification
Each lamp is first held with all expiry inputs low, to separate holding from advancing. It is then held with every expiry input high except its own, which would expose a next-state term wired to the wrong lamp. Next, all three expiry inputs are held high together, so the sequencer must step red, green, amber, red on successive edges; this tells a correct ring apart from one that skips a lamp or runs backwards. Finally, reset is raised mid-cycle while amber is lit, to show that it acts without a clock edge, and it is released with a two-lamp code forced into the state, to show recovery to red.

// File: rtl/lamp_seq_pkg.sv
`timescale 1ns/1ps
package lamp_seq_pkg;
  localparam int unsigned LAMP_W    = 3;
  localparam int unsigned RED_IDX   = 2;
  localparam int unsigned GREEN_IDX = 1;
  localparam int unsigned AMBER_IDX = 0;

  typedef logic [LAMP_W-1:0] lamp_vec_t;

  localparam lamp_vec_t ST_RED   = lamp_vec_t'(1) << RED_IDX;
  localparam lamp_vec_t ST_GREEN = lamp_vec_t'(1) << GREEN_IDX;
  localparam lamp_vec_t ST_AMBER = lamp_vec_t'(1) << AMBER_IDX;
endpackage

// File: rtl/lamp_seq_next.sv
`timescale 1ns/1ps
// Next-state logic: leave the lit lamp only when its own expiry bit is set.
module lamp_seq_next
  import lamp_seq_pkg::*;
(
  input  lamp_vec_t cur_i,
  input  lamp_vec_t expire_i,
  output lamp_vec_t nxt_o
);
  always_comb begin
    case (cur_i)
      ST_RED:   nxt_o = expire_i[RED_IDX]   ? ST_GREEN : ST_RED;
      ST_GREEN: nxt_o = expire_i[GREEN_IDX] ? ST_AMBER : ST_GREEN;
      ST_AMBER: nxt_o = expire_i[AMBER_IDX] ? ST_RED   : ST_AMBER;
      default:  nxt_o = ST_RED;
    endcase
  end
endmodule

// File: rtl/lamp_seq_reg.sv
`timescale 1ns/1ps
// State flops with asynchronous reset to a parameterised code.
module lamp_seq_reg
  import lamp_seq_pkg::*;
#(
  parameter lamp_vec_t RST_VAL = ST_RED
) (
  input  logic      clk_i,
  input  logic      rst_i,
  input  lamp_vec_t d_i,
  output lamp_vec_t q_o
);
  lamp_vec_t state_q;

  always_ff @(posedge clk_i or posedge rst_i) begin
    if (rst_i) state_q <= RST_VAL;
    else       state_q <= d_i;
  end

  assign q_o = state_q;

  // R1: reset holds the register at its reset code
  assert_reset_code_R1: assert property (@(posedge clk_i)
    rst_i |-> (state_q == RST_VAL));
endmodule

// File: rtl/lamp_sequencer.sv
`timescale 1ns/1ps
module lamp_sequencer
  import lamp_seq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic red_done_i,
  input  logic green_done_i,
  input  logic amber_done_i,
  output logic lamp_red_o,
  output logic lamp_amber_o,
  output logic lamp_green_o
);
  lamp_vec_t expire;
  lamp_vec_t state;
  lamp_vec_t state_nxt;

  // Expiry inputs placed at the bit position of the lamp they release.
  assign expire[RED_IDX]   = red_done_i;
  assign expire[GREEN_IDX] = green_done_i;
  assign expire[AMBER_IDX] = amber_done_i;

  lamp_seq_next u_next (
    .cur_i    (state),
    .expire_i (expire),
    .nxt_o    (state_nxt)
  );

  lamp_seq_reg #(.RST_VAL(ST_RED)) u_reg (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (state_nxt),
    .q_o   (state)
  );

  // Lamps are the state bits themselves.
  assign lamp_red_o   = state[RED_IDX];
  assign lamp_green_o = state[GREEN_IDX];
  assign lamp_amber_o = state[AMBER_IDX];

  logic on_red, on_green, on_amber;
  assign on_red   = lamp_red_o   && !lamp_green_o && !lamp_amber_o;
  assign on_green = lamp_green_o && !lamp_red_o   && !lamp_amber_o;
  assign on_amber = lamp_amber_o && !lamp_red_o   && !lamp_green_o;

  assert_red_at_reset_R1: assert property (@(posedge clk_i)
    rst_i |-> on_red);

  assert_red_to_green_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    (on_red && red_done_i) |=> on_green);

  assert_green_to_amber_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    (on_green && green_done_i) |=> on_amber);

  assert_amber_to_red_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (on_amber && amber_done_i) |=> on_red);

  // R5: the lit lamp holds whatever the other expiry inputs do
  assert_red_hold_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (on_red && !red_done_i) |=> on_red);
  assert_green_hold_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (on_green && !green_done_i) |=> on_green);
  assert_amber_hold_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (on_amber && !amber_done_i) |=> on_amber);

  assert_single_lamp_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    ($countones({lamp_red_o, lamp_green_o, lamp_amber_o}) == 1)
      |=> ($countones({lamp_red_o, lamp_green_o, lamp_amber_o}) == 1));

  assert_bad_code_recovers_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    ($countones({lamp_red_o, lamp_green_o, lamp_amber_o}) != 1) |=> on_red);
endmodule

// File: tb/lamp_sequencer_tb_top.sv
`timescale 1ns/1ps
module lamp_sequencer_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b0;
  logic rd = 1'b0, gd = 1'b0, ad = 1'b0;
  logic l_red, l_amber, l_green;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [2:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk; // 250 MHz

  lamp_sequencer dut_i (
    .clk_i        (clk),
    .rst_i        (rst),
    .red_done_i   (rd),
    .green_done_i (gd),
    .amber_done_i (ad),
    .lamp_red_o   (l_red),
    .lamp_amber_o (l_amber),
    .lamp_green_o (l_green)
  );

  // Lamps observed as {red, green, amber}
  function automatic logic [2:0] lamps();
    return {l_red, l_green, l_amber};
  endfunction

  task automatic check(input logic [2:0] act, input logic [2:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: lamps got %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Driver: apply expiry inputs after a falling edge, queue the lamps due one edge later.
  task automatic step(input logic r_in, input logic g_in, input logic a_in,
                      input logic [2:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    #1;
    rd = r_in; gd = g_in; ad = a_in;
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  // Monitor: compare at the falling edge after the rising edge that consumed the inputs.
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item_t it;
      it = sb_q.pop_front();
      check(lamps(), it.exp, it.tag);
      n_tests++;
      if ($countones(lamps()) != 1) begin
        n_fail++;
        $display("FAIL R6: lamps got %b expected one lamp lit", lamps());
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #1 rst = 1'b1;
    repeat (2) @(negedge clk);
    check(lamps(), 3'b100, "R1 reset state");
    #1 rst = 1'b0;

    // R2 / R5: red holds with no expiry, ignores foreign expiries, then advances
    step(1'b0, 1'b0, 1'b0, 3'b100, "R2 red hold");
    step(1'b0, 1'b1, 1'b1, 3'b100, "R5 red ignores others");
    step(1'b1, 1'b0, 1'b0, 3'b010, "R2 red to green");
    // R3 / R5
    step(1'b0, 1'b0, 1'b0, 3'b010, "R3 green hold");
    step(1'b1, 1'b0, 1'b1, 3'b010, "R5 green ignores others");
    step(1'b0, 1'b1, 1'b0, 3'b001, "R3 green to amber");
    // R4 / R5
    step(1'b0, 1'b0, 1'b0, 3'b001, "R4 amber hold");
    step(1'b1, 1'b1, 1'b0, 3'b001, "R5 amber ignores others");
    step(1'b0, 1'b0, 1'b1, 3'b100, "R4 amber to red");
    // All expiries high: one lamp per edge around the ring
    step(1'b1, 1'b1, 1'b1, 3'b010, "R2 ring step");
    step(1'b1, 1'b1, 1'b1, 3'b001, "R3 ring step");
    step(1'b1, 1'b1, 1'b1, 3'b100, "R4 ring step");
    step(1'b1, 1'b1, 1'b1, 3'b010, "R2 ring wrap");
    step(1'b0, 1'b1, 1'b0, 3'b001, "R3 to amber");
    step(1'b0, 1'b0, 1'b0, 3'b001, "R4 amber hold");
    settle();

    // R1: reset mid-cycle lights red before any clock edge
    rst = 1'b1;
    #0.5;
    check(lamps(), 3'b100, "R1 async reset");

    // R7: release reset with a corrupted two-lamp code in the state
    @(negedge clk);
    force dut_i.u_reg.state_q = 3'b110;
    #0.2;
    release dut_i.u_reg.state_q;
    rst = 1'b0;
    #0.3;
    check(lamps(), 3'b110, "R7 corrupt code visible");
    @(negedge clk);
    check(lamps(), 3'b100, "R7 corrupt code recovers");

    step(1'b1, 1'b0, 1'b0, 3'b010, "R2 after recovery");
    settle();

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule